// File: doc/BRIEF.md
# GPIO Bank Register Interface

This block holds the software-visible state of a bank of general-purpose pins and turns it into pad controls. A 32-bit register port with a single-cycle write strobe and a combinational read lets a host set each pin's mode, direction, output level, pull option and input-sense gate. The block also reads back a packed ownership map and a global interrupt-routing choice. Pad input levels pass through a two-flop synchronizer, are gated by the pin's sense control, and are returned on reads and on a level output for a separate interrupt block.

The register space has two parts. One is a set of packed bitmap words in which pin n sits in word n/32 at bit n%32. The other is a pair of 32-bit configuration words per pin, placed at a stride of 8 bytes from offset 0x100. In GPIO mode the pin's own output level and direction drive the pad. In native mode the function signals from the rest of the chip pass straight through to the pad.

Top module: `gpio_bank_regs`

## Requirements
- R1: The ownership map occupies the words at 0x00, 0x04 and 0x08. Pin n is bit n%32 of the word at (n/32)*4. A 0 bit marks a pin kept for firmware. The map resets to parameter OWN_INIT (default all ones), is writable, and its bits above pin 93 read as 0.
- R2: Config word A of pin n is at 0x100 + 8*n. Bit 31 holds the output level, bit 30 the sensed input level, bit 2 the direction (1 input, 0 output), bit 0 the mode (1 GPIO, 0 native). All other bits read 0.
- R3: Config word B of pin n is at 0x104 + 8*n. Bit 2 set disables input sensing. Bits 1:0 hold the pull option, which drives pull_sel[2n+1:2n]. All other bits read 0.
- R4: After reset every pin is an input in GPIO mode with sensing disabled, output level 0 and pull option 0. Word A therefore reads 0x00000005 and word B reads 0x00000004.
- R5: In GPIO mode, pad_oe is high exactly when direction is output, and pad_out is the output-level bit. In native mode, pad_out and pad_oe follow native_out and native_oe.
- R6: A change on pad_in appears in in_level and in bit 30 of word A after two rising clock edges, provided sensing is enabled.
- R7: While sensing is disabled, in_level and bit 30 of word A read 0 whatever the pad level.
- R8: Bit 0 of the word at 0x7C selects which of two interrupt lines the bank uses. It drives irq_route, resets to 0, and the other bits read 0.
- R9: Reads return 0 for unaligned addresses, for unmapped offsets and for config words of pins 94 and above. Writes to these addresses change nothing.
- R10: Writes to bit 30 and to the unused bits of word A have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| pad_in | input | NPINS | Raw pad input levels |
| native_out | input | NPINS | Native function output levels |
| native_oe | input | NPINS | Native function output enables |
| pad_out | output | NPINS | Level driven to the pad |
| pad_oe | output | NPINS | Pad output enable |
| in_level | output | NPINS | Synchronized, sense-gated input levels |
| pull_sel | output | 2*NPINS | Per-pin pull option, two bits per pin |
| irq_route | output | 1 | Interrupt line selection |

## Verification
A corrupted mode or direction bit shows up on pad_oe and pad_out one clock edge after the write that should have set it. A wrong sense gate or a broken synchronizer shows up on in_level, and in bit 30 of the read data, either one edge too early, one edge too late, or with the pad level leaking through while sensing is disabled. A decode error appears at once on a combinational read. It may also appear as a neighbouring pin or register changing after a write aimed elsewhere, which a read-back right after that write reveals.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NPINS = 94,
  parameter int ADDR_W = 12,
  parameter logic [NPINS-1:0] OWN_INIT = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NPINS-1:0]     pad_in,
  input  logic [NPINS-1:0]     native_out,
  input  logic [NPINS-1:0]     native_oe,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     in_level,
  output logic [2*NPINS-1:0]   pull_sel,
  output logic                 irq_route
);

  localparam int NWORDS = (NPINS + 31) / 32;
  localparam int WORD_W = ADDR_W - 2;
  localparam int PIN_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] ROUTE_ADDR = ADDR_W'('h7C);

  logic [NPINS-1:0] own, out_lvl, dir_in, use_gpio, sense_off, sync1, sync2;
  logic [2*NPINS-1:0] pull;
  logic [NWORDS*32-1:0] own_pad;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] cfg_off;
  logic [PIN_W-1:0] cfg_pin;
  logic aligned, own_hit, route_hit, cfg_hit, cfg_b;

  assign aligned   = (addr[1:0] == 2'b00);
  assign word      = addr[ADDR_W-1:2];
  assign own_hit   = aligned && (word < WORD_W'(NWORDS));
  assign route_hit = (addr == ROUTE_ADDR);
  assign cfg_off   = addr - CFG_BASE;
  assign cfg_pin   = cfg_off[ADDR_W-1:3];
  assign cfg_b     = cfg_off[2];
  assign cfg_hit   = aligned && (addr >= CFG_BASE) && (cfg_pin < PIN_W'(NPINS));

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_lvl[i]     <= 1'b0;
          dir_in[i]      <= 1'b1;
          use_gpio[i]    <= 1'b1;
          sense_off[i]   <= 1'b1;
          pull[2*i +: 2] <= 2'b00;
        end else if (wr_en && cfg_hit && cfg_pin == PIN_W'(i)) begin
          if (!cfg_b) begin
            out_lvl[i]  <= wdata[31];
            dir_in[i]   <= wdata[2];
            use_gpio[i] <= wdata[0];
          end else begin
            sense_off[i]   <= wdata[2];
            pull[2*i +: 2] <= wdata[1:0];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own[i] <= OWN_INIT[i];
        else if (wr_en && own_hit && word == WORD_W'(i / 32)) own[i] <= wdata[i % 32];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      irq_route <= 1'b0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      if (wr_en && route_hit) irq_route <= wdata[0];
    end
  end

  assign in_level = sync2 & ~sense_off;
  assign pad_oe   = (use_gpio & ~dir_in) | (~use_gpio & native_oe);
  assign pad_out  = (use_gpio & out_lvl) | (~use_gpio & native_out);
  assign pull_sel = pull;

  always_comb begin
    own_pad = '0;
    own_pad[NPINS-1:0] = own;
  end

  always_comb begin
    rdata = '0;
    if (own_hit) begin
      for (int w = 0; w < NWORDS; w++)
        if (word == WORD_W'(w)) rdata = own_pad[w*32 +: 32];
    end else if (route_hit) begin
      rdata = {31'b0, irq_route};
    end else if (cfg_hit) begin
      for (int p = 0; p < NPINS; p++)
        if (cfg_pin == PIN_W'(p))
          rdata = cfg_b ? {29'b0, sense_off[p], pull[2*p +: 2]}
                        : {out_lvl[p], in_level[p], 27'b0, dir_in[p], 1'b0, use_gpio[p]};
    end
  end

  // R5: a GPIO-mode write to pin 0 word A sets the pad enable from its direction bit
  p_oe_follows_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CFG_BASE && wdata[0]) |=> pad_oe[0] == !$past(wdata[2]));

  // R6: a sensed high level was on the pad two edges earlier
  p_sync_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_level[0] |-> $past(pad_in[0], 2));

  // R7: turning sensing off blanks the level from the next edge
  p_sense_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CFG_BASE + ADDR_W'(4) && wdata[2]) |=> !in_level[0]);

  // R8
  p_route_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && route_hit) |=> irq_route == $past(wdata[0]));

  // R9: the gap between the map and the routing word reads zero
  p_gap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ADDR_W'('h0C) && addr < ROUTE_ADDR) |-> rdata == 32'h0);

endmodule

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;
  localparam int NP = 94;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pad_in = '0, native_out = '0, native_oe = '0;
  logic [NP-1:0] pad_out, pad_oe, in_level;
  logic [2*NP-1:0] pull_sel;
  logic irq_route;
  int checks = 0, fails = 0;

  gpio_bank_regs i_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .native_out(native_out), .native_oe(native_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .in_level(in_level),
    .pull_sel(pull_sel), .irq_route(irq_route));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h100, d);           check("R4 word A", d, 32'h5);
    rd(12'h104 + 8*93, d);    check("R4 word B", d, 32'h4);
    check("R4 pad_oe", 32'(pad_oe[31:0]), 32'h0);
    check("R4 pull", 32'(pull_sel[31:0]), 32'h0);
    rd(12'h000, d);           check("R1 own word0", d, 32'hFFFFFFFF);
    rd(12'h008, d);           check("R1 own word2", d, 32'h3FFFFFFF);
    check("R8 reset", 32'(irq_route), 32'h0);
  endtask

  task automatic t_own;
    logic [31:0] d;
    wr(12'h004, 32'h12345678); rd(12'h004, d); check("R1 word1", d, 32'h12345678);
    wr(12'h008, 32'h00000000); wr(12'h008, 32'hFFFFFFFF);
    rd(12'h008, d); check("R1 top bits", d, 32'h3FFFFFFF);
    rd(12'h000, d); check("R1 neighbour", d, 32'hFFFFFFFF);
  endtask

  task automatic t_output;
    logic [31:0] d;
    wr(12'h128, 32'h80000001);
    check("R5 oe pin5", 32'(pad_oe[5]), 32'h1);
    check("R5 out pin5", 32'(pad_out[5]), 32'h1);
    rd(12'h128, d); check("R2 readback", d, 32'h80000001);
    wr(12'h128, 32'h7FFFFFF9);
    rd(12'h128, d); check("R10 ro bits", d, 32'h00000001);
    check("R5 out low", 32'(pad_out[5]), 32'h0);
    wr(12'h128, 32'h00000005);
    check("R5 input dir", 32'(pad_oe[5]), 32'h0);
  endtask

  task automatic t_native;
    wr(12'h128, 32'h80000000);
    native_out[5] = 1; native_oe[5] = 1; #0.5;
    check("R5 native oe", 32'(pad_oe[5]), 32'h1);
    check("R5 native out", 32'(pad_out[5]), 32'h1);
    native_out[5] = 0; native_oe[5] = 0; #0.5;
    check("R5 native off", 32'({pad_oe[5], pad_out[5]}), 32'h0);
  endtask

  task automatic t_input;
    logic [31:0] d;
    wr(12'h244, 32'h0);
    @(negedge clk); pad_in[40] = 1;
    @(negedge clk); rd(12'h240, d); check("R6 one edge", 32'(d[30]), 32'h0);
    @(negedge clk); rd(12'h240, d); check("R6 two edges", 32'(d[30]), 32'h1);
    check("R6 in_level", 32'(in_level[40]), 32'h1);
    wr(12'h244, 32'h4);
    rd(12'h240, d); check("R7 gated read", 32'(d[30]), 32'h0);
    check("R7 gated level", 32'(in_level[40]), 32'h0);
    wr(12'h244, 32'hFFFFFFFB);
    rd(12'h244, d); check("R3 readback", d, 32'h3);
    check("R3 pull_sel", 32'(pull_sel[81:80]), 32'h3);
    check("R3 sensed again", 32'(in_level[40]), 32'h1);
  endtask

  task automatic t_route;
    logic [31:0] d;
    wr(12'h07C, 32'hFFFFFFFF);
    rd(12'h07C, d); check("R8 readback", d, 32'h1);
    check("R8 output", 32'(irq_route), 32'h1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(12'h3F0, 32'hFFFFFFFF); rd(12'h3F0, d); check("R9 pin94", d, 32'h0);
    rd(12'h3E8, d); check("R9 pin93 intact", d, 32'h5);
    wr(12'h040, 32'hFFFFFFFF); rd(12'h040, d); check("R9 gap", d, 32'h0);
    wr(12'h102, 32'h80000000); rd(12'h100, d); check("R9 unaligned write", d, 32'h5);
    rd(12'h102, d); check("R9 unaligned read", d, 32'h0);
    wr(12'h07D, 32'h0); check("R9 route intact", 32'(irq_route), 32'h1);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_own;
    t_output;
    t_native;
    t_input;
    t_route;
    t_unmapped;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule